// File: doc/BRIEF.md
# Video Memory DMA Slot Sequencer

This block paces DMA transfers into video memory inside a display controller. A command decoder hands it a start request together with the current command code, a destination address, the two length bytes and the source-select byte. A bus or copy transfer starts at once. A fill transfer is armed first and starts when the first data-port FIFO entry is valid. The fill value and the destination address come from that entry.

A horizontal slot counter advances on a slot-enable pulse. On every slot pulse that is not reserved for memory refresh, the block emits one write strobe with the current destination address, the fill data and the latched destination code. After each transfer the address advances by the auto-increment amount and the remaining length drops by one. The busy flag falls when the length reaches zero.

The refresh slots depend on the line-width mode. While a DMA with a destination other than VRAM is running, one extra slot is taken ahead of each refresh slot. Transfers from the source bus and copy reads are modelled as write strobes only.

Top module: `vdma_seq`

## Requirements
- R1: After synchronous active-low reset, `busy` and `wr_strobe` are low, `slot_idx` is 0 and `len_remain` is 0.
- R2: `slot_idx` advances by one on each `slot_tick` and holds otherwise. It wraps to 0 after slot 209 when `wide_mode`=0, and after slot 419 when `wide_mode`=1.
- R3: A `start_req` with `dma_enable`=1, `cmd_code[5]`=1 and `src_high[7:6]` not equal to 2'b10 sets `busy` on the next clock edge. It loads the address from `cmd_addr`, the length from {`len_hi`,`len_lo`} and `wr_code` from `cmd_code[3:0]`.
- R4: A qualifying `start_req` with `src_high[7:6]`=2'b10 arms a fill and leaves `busy` low. The fill starts on the edge where `fifo_valid` is high: `busy` rises, and the address and data come from `fifo_addr` and `fifo_data`.
- R5: A `start_req` has no effect when `dma_enable`=0 or `cmd_code[5]`=0.
- R6: While `busy`, each unblocked `slot_tick` gives exactly one `wr_strobe` in that cycle, with `wr_addr` equal to the current address. The address then grows by `auto_inc`. There is no strobe while idle.
- R7: Each transfer lowers `len_remain` by one. `busy` clears on the transfer that makes it zero, so a length N≥1 gives N strobes.
- R8: With `wide_mode`=1, slots 37, 69, 102, 133, 165, 197 and every slot ≥210 produce no transfer.
- R9: With `wide_mode`=0, slots 24, 56, 88, 120 and 152 produce no transfer.
- R10: With `wide_mode`=1 and a running DMA whose code[3:0] is not 4'b0001 (VRAM write), slots 34, 66, 99, 130, 162 and 194 are also blocked. They are free for code 4'b0001.
- R11: With `wide_mode`=0 and a running DMA whose code[3:0] is not 4'b0001, slots 21, 53, 85, 117 and 149 are also blocked.
- R12: A blocked slot pulse leaves `len_remain` and `wr_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_tick | input | 1 | Slot-enable pulse; advances the slot counter |
| wide_mode | input | 1 | 1 = 40-cell line, 0 = 32-cell line |
| dma_enable | input | 1 | DMA globally allowed |
| cmd_code | input | 6 | Command code; bit 5 requests DMA, bits 3:0 select the destination |
| cmd_addr | input | 16 | Destination address for immediate-start transfers |
| src_high | input | 8 | Source-select byte; bits 7:6 = 2'b10 select fill |
| len_hi | input | 8 | Length high byte |
| len_lo | input | 8 | Length low byte |
| auto_inc | input | 8 | Address step per transfer |
| start_req | input | 1 | Start pulse from the command decoder |
| fifo_valid | input | 1 | First FIFO entry is valid |
| fifo_addr | input | 16 | Address of the first FIFO entry |
| fifo_data | input | 16 | Value of the first FIFO entry |
| busy | output | 1 | DMA running |
| wr_strobe | output | 1 | One transfer this cycle |
| wr_addr | output | 16 | Current destination address |
| wr_data | output | 16 | Fill value (0 for non-fill transfers) |
| wr_code | output | 4 | Latched destination code |
| len_remain | output | 16 | Remaining transfer count |
| slot_idx | output | 9 | Current horizontal slot |

## Verification
The hardest case to reach is a specific slot number, in a specific width mode, while a DMA of a chosen destination code is running. The stolen slots exist only under that combination. Each table vector therefore resets the block, starts a long DMA with the wanted code, and issues exactly as many slot pulses as the target slot number. It then raises one more pulse and looks for a strobe in that cycle. Slots just next to the reserved ones are included, so an off-by-one in the slot lists is caught.

// File: rtl/vdma_pkg.sv
// Package: shared constants for the DMA slot sequencer.
// Assumes slot numbers fit in 9 bits and the length is built from two bytes.
package vdma_pkg;
    localparam int SLOT_W      = 9;
    localparam int WIDE_LAST   = 419;
    localparam int NARROW_LAST = 209;
    localparam int WIDE_BAND   = 210;
    localparam logic [3:0] CODE_VRAM_WR = 4'b0001;
    localparam int N_WIDE   = 6;
    localparam int N_NARROW = 5;
    localparam int WIDE_REF   [N_WIDE]   = '{37, 69, 102, 133, 165, 197};
    localparam int WIDE_STEAL [N_WIDE]   = '{34, 66, 99, 130, 162, 194};
    localparam int NARROW_REF   [N_NARROW] = '{24, 56, 88, 120, 152};
    localparam int NARROW_STEAL [N_NARROW] = '{21, 53, 85, 117, 149};
endpackage

// File: rtl/vdma_slot_ctr.sv
// Module: horizontal slot counter.
// Advances on slot_tick and wraps at a width-mode-dependent last slot.
// Assumes that if the mode changes while the count is past the new last slot,
// the next pulse wraps the count to zero.
module vdma_slot_ctr
    import vdma_pkg::*;
#(
    parameter int SW = SLOT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_tick,
    input  logic          wide_mode,
    output logic [SW-1:0] slot
);
    localparam logic [SW-1:0] LAST_W = SW'(WIDE_LAST);
    localparam logic [SW-1:0] LAST_N = SW'(NARROW_LAST);

    logic [SW-1:0] last;
    // Pick the wrap point for the current line width.
    always_comb last = wide_mode ? LAST_W : LAST_N;

    // Count slot pulses, wrapping after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot <= '0;
        else if (slot_tick)
            slot <= (slot >= last) ? '0 : slot + 1'b1;
    end

    // R2: a pulse either steps the count by one or wraps it to zero.
    assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |=> (slot == '0 || slot == $past(slot) + 1'b1));
    // R2: without a pulse the count holds.
    assert_slot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> $stable(slot));
endmodule

// File: rtl/vdma_refresh_map.sv
// Module: decides whether the current slot is reserved.
// Purely combinational. A reserved slot is either a fixed refresh slot or,
// while steal_en is high, a slot taken for a non-VRAM destination.
module vdma_refresh_map
    import vdma_pkg::*;
#(
    parameter int SW = SLOT_W
) (
    input  logic [SW-1:0] slot,
    input  logic          wide_mode,
    input  logic          steal_en,
    output logic          blocked
);
    logic hit_ref;
    logic hit_steal;

    // Compare the slot against the tables for the selected width.
    always_comb begin
        hit_ref   = 1'b0;
        hit_steal = 1'b0;
        if (wide_mode) begin
            for (int i = 0; i < N_WIDE; i++) begin
                if (slot == SW'(WIDE_REF[i]))   hit_ref   = 1'b1;
                if (slot == SW'(WIDE_STEAL[i])) hit_steal = 1'b1;
            end
            if (slot >= SW'(WIDE_BAND)) hit_ref = 1'b1;
        end else begin
            for (int i = 0; i < N_NARROW; i++) begin
                if (slot == SW'(NARROW_REF[i]))   hit_ref   = 1'b1;
                if (slot == SW'(NARROW_STEAL[i])) hit_steal = 1'b1;
            end
        end
    end

    // Merge fixed refresh with the conditional steal.
    always_comb blocked = hit_ref | (steal_en & hit_steal);
endmodule

// File: rtl/vdma_xfer_engine.sv
// Module: DMA start, arming and transfer bookkeeping.
// Starts bus or copy transfers immediately and arms fills until the first
// FIFO entry is valid. It issues one strobe per free slot pulse and counts
// the length down to zero. Assumes start requests are ignored while armed
// or busy.
module vdma_xfer_engine
    import vdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int IW = 8,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_tick,
    input  logic          blocked,
    input  logic          dma_enable,
    input  logic [5:0]    cmd_code,
    input  logic [AW-1:0] cmd_addr,
    input  logic [7:0]    src_high,
    input  logic [BW-1:0] len_hi,
    input  logic [BW-1:0] len_lo,
    input  logic [IW-1:0] auto_inc,
    input  logic          start_req,
    input  logic          fifo_valid,
    input  logic [AW-1:0] fifo_addr,
    input  logic [DW-1:0] fifo_data,
    output logic          busy,
    output logic          steal_en,
    output logic          wr_strobe,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [3:0]    wr_code,
    output logic [2*BW-1:0] len_remain
);
    localparam int LW = 2 * BW;

    logic          armed;
    logic          go;
    logic          is_fill;
    logic [LW-1:0] len_next;

    // Qualify a start request and classify it as fill or immediate.
    always_comb begin
        go       = start_req & dma_enable & cmd_code[5];
        is_fill  = (src_high[7:6] == 2'b10);
        len_next = len_remain - 1'b1;
    end

    // One transfer per free slot pulse while running.
    always_comb wr_strobe = busy & slot_tick & ~blocked;
    // Extra slots are stolen only for a running non-VRAM destination.
    always_comb steal_en  = busy & (wr_code != CODE_VRAM_WR);

    // Sequencing state: arming, start capture, per-transfer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            armed      <= 1'b0;
            len_remain <= '0;
            wr_addr    <= '0;
            wr_data    <= '0;
            wr_code    <= '0;
        end else if (busy) begin
            if (wr_strobe) begin
                len_remain <= len_next;
                wr_addr    <= wr_addr + AW'(auto_inc);
                if (len_next == '0) busy <= 1'b0;
            end
        end else if (armed) begin
            if (fifo_valid) begin
                armed      <= 1'b0;
                busy       <= 1'b1;
                wr_addr    <= fifo_addr;
                wr_data    <= fifo_data;
                wr_code    <= cmd_code[3:0];
                len_remain <= {len_hi, len_lo};
            end
        end else if (go) begin
            if (is_fill) begin
                armed <= 1'b1;
            end else begin
                busy       <= 1'b1;
                wr_addr    <= cmd_addr;
                wr_data    <= '0;
                wr_code    <= cmd_code[3:0];
                len_remain <= {len_hi, len_lo};
            end
        end
    end

    // R6: no strobe leaves the block while idle.
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_strobe);
    // R7: every transfer lowers the remaining length by one.
    assert_len_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> (len_remain == $past(len_remain) - 1'b1));
    // R7: the transfer that reaches zero ends the run.
    assert_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && len_remain == LW'(1)) |=> !busy);
    // R12: a running DMA without a strobe keeps length and address.
    assert_hold_on_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_strobe) |=> ($stable(len_remain) && $stable(wr_addr)));
endmodule

// File: rtl/vdma_seq.sv
// Module: top of the DMA slot sequencer.
// Ties the slot counter, the refresh map and the transfer engine together.
// Assumes slot_tick is a single-cycle pulse and that the inputs are stable
// around the clock edge.
module vdma_seq
    import vdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int INC_W  = 8,
    parameter int BYTE_W = 8,
    parameter int SW     = SLOT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slot_tick,
    input  logic                wide_mode,
    input  logic                dma_enable,
    input  logic [5:0]          cmd_code,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [7:0]          src_high,
    input  logic [BYTE_W-1:0]   len_hi,
    input  logic [BYTE_W-1:0]   len_lo,
    input  logic [INC_W-1:0]    auto_inc,
    input  logic                start_req,
    input  logic                fifo_valid,
    input  logic [ADDR_W-1:0]   fifo_addr,
    input  logic [DATA_W-1:0]   fifo_data,
    output logic                busy,
    output logic                wr_strobe,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic [3:0]          wr_code,
    output logic [2*BYTE_W-1:0] len_remain,
    output logic [SW-1:0]       slot_idx
);
    logic blocked;
    logic steal_en;

    vdma_slot_ctr #(.SW(SW)) u_slot (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick),
        .wide_mode(wide_mode), .slot(slot_idx)
    );

    vdma_refresh_map #(.SW(SW)) u_map (
        .slot(slot_idx), .wide_mode(wide_mode),
        .steal_en(steal_en), .blocked(blocked)
    );

    vdma_xfer_engine #(.AW(ADDR_W), .DW(DATA_W), .IW(INC_W), .BW(BYTE_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .blocked(blocked),
        .dma_enable(dma_enable), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .src_high(src_high), .len_hi(len_hi), .len_lo(len_lo),
        .auto_inc(auto_inc), .start_req(start_req), .fifo_valid(fifo_valid),
        .fifo_addr(fifo_addr), .fifo_data(fifo_data), .busy(busy),
        .steal_en(steal_en), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_code(wr_code), .len_remain(len_remain)
    );

    // R8: the wide-mode upper band never carries a transfer.
    assert_top_band_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && slot_idx >= SW'(WIDE_BAND)) |-> !wr_strobe);
    // R6: a strobe only ever accompanies a slot pulse.
    assert_strobe_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> slot_tick);
endmodule

// File: tb/tb_vdma_seq.sv
module tb_vdma_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_tick = 1'b0;
    logic        wide_mode = 1'b1;
    logic        dma_enable = 1'b0;
    logic [5:0]  cmd_code = '0;
    logic [15:0] cmd_addr = '0;
    logic [7:0]  src_high = '0;
    logic [7:0]  len_hi = '0;
    logic [7:0]  len_lo = '0;
    logic [7:0]  auto_inc = '0;
    logic        start_req = 1'b0;
    logic        fifo_valid = 1'b0;
    logic [15:0] fifo_addr = '0;
    logic [15:0] fifo_data = '0;
    logic        busy, wr_strobe;
    logic [15:0] wr_addr, wr_data, len_remain;
    logic [3:0]  wr_code;
    logic [8:0]  slot_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    vdma_seq dut (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .wide_mode(wide_mode),
        .dma_enable(dma_enable), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .src_high(src_high), .len_hi(len_hi), .len_lo(len_lo),
        .auto_inc(auto_inc), .start_req(start_req), .fifo_valid(fifo_valid),
        .fifo_addr(fifo_addr), .fifo_data(fifo_data), .busy(busy),
        .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_code(wr_code), .len_remain(len_remain), .slot_idx(slot_idx)
    );

    // Vector: {wide, code[3:0], slot[8:0], expected strobe}
    localparam int NV = 19;
    localparam logic [14:0] VECS [NV] = '{
        {1'b1, 4'd1, 9'd37,  1'b0}, {1'b1, 4'd1, 9'd36,  1'b1},
        {1'b1, 4'd1, 9'd197, 1'b0}, {1'b1, 4'd1, 9'd209, 1'b1},
        {1'b1, 4'd1, 9'd210, 1'b0}, {1'b1, 4'd1, 9'd419, 1'b0},
        {1'b1, 4'd1, 9'd34,  1'b1}, {1'b1, 4'd3, 9'd34,  1'b0},
        {1'b1, 4'd3, 9'd194, 1'b0}, {1'b1, 4'd3, 9'd35,  1'b1},
        {1'b1, 4'd5, 9'd99,  1'b0}, {1'b0, 4'd1, 9'd24,  1'b0},
        {1'b0, 4'd1, 9'd152, 1'b0}, {1'b0, 4'd1, 9'd21,  1'b1},
        {1'b0, 4'd3, 9'd21,  1'b0}, {1'b0, 4'd3, 9'd149, 1'b0},
        {1'b0, 4'd1, 9'd100, 1'b1}, {1'b0, 4'd3, 9'd209, 1'b1},
        {1'b0, 4'd1, 9'd0,   1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; slot_tick = 1'b0; start_req = 1'b0; fifo_valid = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0; #1;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slot_tick = 1'b1;
            @(negedge clk); slot_tick = 1'b0;
        end
        #1;
    endtask

    task automatic strobe_tick(output logic s, output logic [15:0] a, output logic [15:0] d);
        @(negedge clk); slot_tick = 1'b1; #1;
        s = wr_strobe; a = wr_addr; d = wr_data;
        @(negedge clk); slot_tick = 1'b0; #1;
    endtask

    task automatic setup_run(input logic w, input logic [3:0] code, input logic [15:0] len,
                             input logic [15:0] addr, input logic [7:0] inc);
        wide_mode = w; dma_enable = 1'b1; cmd_code = {2'b10, code}; src_high = 8'h00;
        len_hi = len[15:8]; len_lo = len[7:0]; cmd_addr = addr; auto_inc = inc;
        pulse_start();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic s;
        logic [15:0] a, d, l0, a0;

        // R1: reset state
        do_reset(); #1;
        chk("R1 busy", busy, 0);
        chk("R1 strobe", wr_strobe, 0);
        chk("R1 slot", slot_idx, 0);
        chk("R1 len", len_remain, 0);

        // Slot-table vectors (R8 R9 R10 R11)
        for (int v = 0; v < NV; v++) begin
            do_reset();
            setup_run(VECS[v][14], VECS[v][13:10], 16'hFFFF, 16'h0000, 8'd2);
            tick_n(int'(VECS[v][9:1]));
            chk("R8/R9 slot position", slot_idx, VECS[v][9:1]);
            strobe_tick(s, a, d);
            if (VECS[v][14]) chk("R8 R10 wide slot strobe", s, VECS[v][0]);
            else             chk("R9 R11 narrow slot strobe", s, VECS[v][0]);
        end

        // R2: wrap points
        do_reset(); wide_mode = 1'b0; #1;
        tick_n(209); chk("R2 narrow last", slot_idx, 209);
        tick_n(1);   chk("R2 narrow wrap", slot_idx, 0);
        do_reset(); wide_mode = 1'b1;
        tick_n(419); chk("R2 wide last", slot_idx, 419);
        tick_n(1);   chk("R2 wide wrap", slot_idx, 0);
        repeat (3) @(negedge clk); #1;
        chk("R2 hold without tick", slot_idx, 0);

        // R3 R6 R7: immediate start, three transfers
        do_reset();
        setup_run(1'b1, 4'd1, 16'd3, 16'h1000, 8'd2);
        chk("R3 busy", busy, 1);
        chk("R3 code", wr_code, 4'd1);
        chk("R3 len", len_remain, 3);
        for (int k = 0; k < 3; k++) begin
            strobe_tick(s, a, d);
            chk("R6 strobe", s, 1);
            chk("R6 addr", a, 16'h1000 + 16'(2 * k));
            chk("R7 len", len_remain, 16'(2 - k));
        end
        chk("R7 busy cleared", busy, 0);
        strobe_tick(s, a, d);
        chk("R6 idle no strobe", s, 0);

        // R5: disabled or no DMA bit
        do_reset();
        wide_mode = 1'b1; dma_enable = 1'b0; cmd_code = 6'b100001; len_lo = 8'd4;
        pulse_start(); chk("R5 dma disabled", busy, 0);
        strobe_tick(s, a, d); chk("R5 no strobe", s, 0);
        dma_enable = 1'b1; cmd_code = 6'b000001;
        pulse_start(); chk("R5 no dma bit", busy, 0);
        strobe_tick(s, a, d); chk("R5 no strobe 2", s, 0);

        // R4: fill arms then starts on FIFO entry
        do_reset();
        wide_mode = 1'b1; dma_enable = 1'b1; cmd_code = 6'b100001; src_high = 8'h80;
        len_hi = 8'd0; len_lo = 8'd2; auto_inc = 8'd1; cmd_addr = 16'h5555;
        pulse_start();
        repeat (2) @(negedge clk); #1;
        chk("R4 armed not busy", busy, 0);
        @(negedge clk); fifo_addr = 16'h0200; fifo_data = 16'hABCD; fifo_valid = 1'b1;
        @(negedge clk); fifo_valid = 1'b0; #1;
        chk("R4 busy", busy, 1);
        strobe_tick(s, a, d);
        chk("R4 strobe", s, 1);
        chk("R4 addr", a, 16'h0200);
        chk("R4 data", d, 16'hABCD);

        // R12: blocked slot leaves state unchanged
        do_reset();
        setup_run(1'b1, 4'd1, 16'hFFFF, 16'h0000, 8'd4);
        tick_n(37);
        l0 = len_remain; a0 = wr_addr;
        strobe_tick(s, a, d);
        chk("R12 no strobe", s, 0);
        chk("R12 len held", len_remain, l0);
        chk("R12 addr held", wr_addr, a0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule